// File: doc/BRIEF.md
# Triple-Buffer Frame Pointer Synchronizer

This block decides which of three frame stores a video writer fills and which one a video reader scans. The two sides run on unrelated clocks. Each side signals the beginning and the end of every frame in its own domain. The block never lets the reader show a frame that mixes pixels from two different written frames. It keeps the two slot pointers apart by skipping or repeating whole frames. No pointer wiring outside the block is needed, because the writer's progress alone steers what the reader picks up.

A finished write frame is published to the reader as the latest complete slot. The writer then moves on circularly and jumps over the slot the reader holds. The reader samples the latest published slot only when it starts a frame. If that slot is the one it already holds, or the one the writer is filling, the reader shows its current slot again. When error-repeat is enabled, a write frame whose size check failed is never published. The writer overwrites it in the same slot. Slot indices cross between the domains as 2-bit gray codes held in registers, followed by two flip-flops in the receiving domain. Per-side saturating counters record the skipped frames and the repeated frames.

Top module: `tribuf_frame_sync`

## Requirements
- R1: After reset (w_rst_n and r_rst_n low at a rising edge of their clocks), w_slot and r_slot are 0 and all four counters are 0. Slot indices only take the values 0, 1 and 2.
- R2: A write frame is accepted when w_done is high while the writer is active. If it is accepted as good (not w_size_bad, or err_repeat_en low), the writer publishes its slot and moves to (w_slot+1) mod 3. If the reader's synchronized slot equals that value, the writer moves to (w_slot+2) mod 3 instead and w_skip_cnt increments.
- R3: If an accepted write frame has w_size_bad high while err_repeat_en is high, w_slot stays the same, nothing is published, and w_rep_cnt increments.
- R4: A start while the side is already active, and a done while it is idle, are ignored. start enters the active state only from idle. When start and done are both high while active, only done acts.
- R5: On an accepted r_start (reader idle), let p be the synchronized published slot and q the synchronized writer slot. If p differs from both r_slot and q, r_slot becomes p. Otherwise r_slot is unchanged and r_rep_cnt increments.
- R6: When the reader takes a new slot that is not (r_slot+1) mod 3, r_skip_cnt increments. When the writer skips (R2), w_skip_cnt increments.
- R7: A slot index is sent as a register holding its gray code (0→00, 1→01, 2→11) and passes two flip-flops in the receiving domain. With the two clocks equal, a change made at edge k is used by decisions from edge k+3 on.
- R8: Each counter holds at its all-ones value (CNT_W bits, default 16) and never decreases except on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| w_clk | input | 1 | Writer clock |
| w_rst_n | input | 1 | Writer synchronous reset, active low |
| w_start | input | 1 | Writer frame begins |
| w_done | input | 1 | Writer frame ends |
| w_size_bad | input | 1 | Frame that ends with w_done failed its size check |
| err_repeat_en | input | 1 | Rewrite failed frames in the same slot |
| r_clk | input | 1 | Reader clock |
| r_rst_n | input | 1 | Reader synchronous reset, active low |
| r_start | input | 1 | Reader frame begins |
| r_done | input | 1 | Reader frame ends |
| w_slot | output | 2 | Slot the writer fills |
| r_slot | output | 2 | Slot the reader scans |
| w_skip_cnt | output | CNT_W | Writer skips, saturating |
| w_rep_cnt | output | CNT_W | Writer repeats after a size error, saturating |
| r_skip_cnt | output | CNT_W | Reader non-sequential jumps, saturating |
| r_rep_cnt | output | CNT_W | Reader repeated frames, saturating |

## Verification
A wrong published slot or a stale synchronizer stage does not show at once. It shows as a wrong r_slot or a wrong r_rep_cnt at the first reader frame start that comes three or more edges after the bad value arose. A wrong writer choice shows as a wrong w_slot, and usually a wrong w_skip_cnt, in the edge that accepts the frame end. The bench drives both domains from one clock so the synchronizer delay is exact. It compares every output with a behavioural model on every cycle.

// File: rtl/tfs_pkg.sv
// Shared slot type and helpers for the triple-buffer pointer logic.
// Assumes exactly three slots; index 3 is never produced.
package tfs_pkg;
    localparam int SLOT_W = 2;
    localparam int NSLOT  = 3;
    typedef logic [SLOT_W-1:0] slot_t;

    // Next slot in circular order.
    function automatic slot_t slot_next(slot_t s);
        return (s == slot_t'(NSLOT - 1)) ? slot_t'(0) : s + slot_t'(1);
    endfunction

    // Binary to gray code.
    function automatic slot_t to_gray(slot_t b);
        return b ^ (b >> 1);
    endfunction

    // Gray code to binary.
    function automatic slot_t from_gray(slot_t g);
        return {g[1], g[1] ^ g[0]};
    endfunction
endpackage

// File: rtl/tfs_sync2.sv
// Two-flop synchronizer for a registered gray-coded bus.
// Assumes the source bus comes straight from a register in another domain.
module tfs_sync2 #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    // Shift the foreign value through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/tfs_sat_cnt.sv
// Event counter that holds at its all-ones value.
// Assumes inc is a single-cycle strobe in the counter's own domain.
module tfs_sat_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    // Count strobes until full.
    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt <= '0;
        else if (inc && cnt != TOP) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/tfs_write_side.sv
// Writer slot control: tracks the active frame, publishes good frames,
// and steps to the next slot while avoiding the reader's slot.
// Assumes rd_slot_g is already synchronized into this domain.
module tfs_write_side
    import tfs_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  start,
    input  logic  done,
    input  logic  size_bad,
    input  logic  err_repeat_en,
    input  slot_t rd_slot_g,
    output slot_t slot,
    output slot_t slot_g,
    output slot_t pub_g,
    output slot_t rd_seen,
    output logic  act,
    output logic  skip_inc,
    output logic  rep_inc
);
    slot_t step1;
    slot_t nxt;
    logic  hop;
    logic  accept;
    logic  redo;

    // Choose the next slot and the event strobes.
    always_comb begin
        rd_seen  = from_gray(rd_slot_g);
        step1    = slot_next(slot);
        hop      = (step1 == rd_seen);
        nxt      = hop ? slot_next(step1) : step1;
        accept   = act && done;
        redo     = size_bad && err_repeat_en;
        rep_inc  = accept && redo;
        skip_inc = accept && !redo && hop;
    end

    // Frame state, current slot and published slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act    <= 1'b0;
            slot   <= '0;
            slot_g <= '0;
            pub_g  <= '0;
        end else if (!act) begin
            if (start) act <= 1'b1;
        end else if (done) begin
            act <= 1'b0;
            if (!redo) begin
                pub_g  <= to_gray(slot);
                slot   <= nxt;
                slot_g <= to_gray(nxt);
            end
        end
    end
endmodule

// File: rtl/tfs_read_side.sv
// Reader slot control: at each frame start takes the newest published
// slot unless it is its own or the writer's, otherwise repeats.
// Assumes both gray inputs are already synchronized into this domain.
module tfs_read_side
    import tfs_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  start,
    input  logic  done,
    input  slot_t pub_g,
    input  slot_t wr_slot_g,
    output slot_t slot,
    output slot_t slot_g,
    output slot_t wr_seen,
    output logic  skip_inc,
    output logic  rep_inc
);
    slot_t pub_seen;
    logic  act;
    logic  accept;
    logic  take;

    // Decide whether a frame start moves to the published slot.
    always_comb begin
        pub_seen = from_gray(pub_g);
        wr_seen  = from_gray(wr_slot_g);
        accept   = !act && start;
        take     = (pub_seen != slot) && (pub_seen != wr_seen);
        rep_inc  = accept && !take;
        skip_inc = accept && take && (pub_seen != slot_next(slot));
    end

    // Frame state and current slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act    <= 1'b0;
            slot   <= '0;
            slot_g <= '0;
        end else if (accept) begin
            act <= 1'b1;
            if (take) begin
                slot   <= pub_seen;
                slot_g <= to_gray(pub_seen);
            end
        end else if (act && done) begin
            act <= 1'b0;
        end
    end
endmodule

// File: rtl/tribuf_frame_sync.sv
// Triple-buffer frame pointer synchronizer: writer and reader slot
// control in two unrelated clock domains, joined by gray synchronizers.
// Assumes frame start/done strobes are single-cycle in their own domain.
module tribuf_frame_sync
    import tfs_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             w_clk,
    input  logic             w_rst_n,
    input  logic             w_start,
    input  logic             w_done,
    input  logic             w_size_bad,
    input  logic             err_repeat_en,
    input  logic             r_clk,
    input  logic             r_rst_n,
    input  logic             r_start,
    input  logic             r_done,
    output logic [1:0]       w_slot,
    output logic [1:0]       r_slot,
    output logic [CNT_W-1:0] w_skip_cnt,
    output logic [CNT_W-1:0] w_rep_cnt,
    output logic [CNT_W-1:0] r_skip_cnt,
    output logic [CNT_W-1:0] r_rep_cnt
);
    slot_t w_slot_g, w_pub_g, r_slot_g;
    slot_t rd_g_at_w, pub_g_at_r, wr_g_at_r;
    slot_t w_rd_seen, r_wr_seen;
    logic  w_act;
    logic  w_skip_inc, w_rep_inc, r_skip_inc, r_rep_inc;

    tfs_write_side u_wr (
        .clk(w_clk), .rst_n(w_rst_n), .start(w_start), .done(w_done),
        .size_bad(w_size_bad), .err_repeat_en(err_repeat_en),
        .rd_slot_g(rd_g_at_w), .slot(w_slot), .slot_g(w_slot_g),
        .pub_g(w_pub_g), .rd_seen(w_rd_seen), .act(w_act),
        .skip_inc(w_skip_inc), .rep_inc(w_rep_inc)
    );

    tfs_read_side u_rd (
        .clk(r_clk), .rst_n(r_rst_n), .start(r_start), .done(r_done),
        .pub_g(pub_g_at_r), .wr_slot_g(wr_g_at_r), .slot(r_slot),
        .slot_g(r_slot_g), .wr_seen(r_wr_seen),
        .skip_inc(r_skip_inc), .rep_inc(r_rep_inc)
    );

    tfs_sync2 #(.W(SLOT_W)) u_sync_rd (
        .clk(w_clk), .rst_n(w_rst_n), .d(r_slot_g), .q(rd_g_at_w));
    tfs_sync2 #(.W(SLOT_W)) u_sync_pub (
        .clk(r_clk), .rst_n(r_rst_n), .d(w_pub_g), .q(pub_g_at_r));
    tfs_sync2 #(.W(SLOT_W)) u_sync_wr (
        .clk(r_clk), .rst_n(r_rst_n), .d(w_slot_g), .q(wr_g_at_r));

    tfs_sat_cnt #(.W(CNT_W)) u_cnt_wskip (
        .clk(w_clk), .rst_n(w_rst_n), .inc(w_skip_inc), .cnt(w_skip_cnt));
    tfs_sat_cnt #(.W(CNT_W)) u_cnt_wrep (
        .clk(w_clk), .rst_n(w_rst_n), .inc(w_rep_inc), .cnt(w_rep_cnt));
    tfs_sat_cnt #(.W(CNT_W)) u_cnt_rskip (
        .clk(r_clk), .rst_n(r_rst_n), .inc(r_skip_inc), .cnt(r_skip_cnt));
    tfs_sat_cnt #(.W(CNT_W)) u_cnt_rrep (
        .clk(r_clk), .rst_n(r_rst_n), .inc(r_rep_inc), .cnt(r_rep_cnt));
endmodule

// File: rtl/tfs_checker.sv
// Property checker for tribuf_frame_sync, attached by bind.
// Assumes it sees the top's ports and a few internal nets.
module tfs_checker #(
    parameter int CNT_W = 16
) (
    input logic             w_clk,
    input logic             w_rst_n,
    input logic             w_start,
    input logic             w_done,
    input logic             w_size_bad,
    input logic             err_repeat_en,
    input logic             r_clk,
    input logic             r_rst_n,
    input logic             r_start,
    input logic [1:0]       w_slot,
    input logic [1:0]       r_slot,
    input logic [1:0]       w_pub_g,
    input logic [1:0]       w_rd_seen,
    input logic [1:0]       r_wr_seen,
    input logic             w_act,
    input logic [CNT_W-1:0] w_skip_cnt,
    input logic [CNT_W-1:0] r_rep_cnt
);
    localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};

    a_r1_wslot_legal: assert property (@(posedge w_clk) disable iff (!w_rst_n)
        w_slot != 2'd3);
    a_r1_rslot_legal: assert property (@(posedge r_clk) disable iff (!r_rst_n)
        r_slot != 2'd3);
    a_r2_good_moves: assert property (@(posedge w_clk) disable iff (!w_rst_n)
        (w_act && w_done && !(w_size_bad && err_repeat_en))
        |=> (w_slot != $past(w_slot)) && (w_slot != $past(w_rd_seen)));
    a_r3_bad_stays: assert property (@(posedge w_clk) disable iff (!w_rst_n)
        (w_act && w_done && w_size_bad && err_repeat_en)
        |=> $stable(w_slot) && $stable(w_pub_g));
    a_r4_idle_done_ignored: assert property (@(posedge w_clk) disable iff (!w_rst_n)
        (!w_act && w_done) |=> $stable(w_slot) && $stable(w_pub_g));
    a_r5_reader_avoids_writer: assert property (@(posedge r_clk) disable iff (!r_rst_n)
        (r_slot != $past(r_slot)) |-> ($past(r_start) && (r_slot != $past(r_wr_seen))));
    a_r8_wskip_holds: assert property (@(posedge w_clk) disable iff (!w_rst_n)
        (w_skip_cnt == FULL) |=> (w_skip_cnt == FULL));
    a_r8_rrep_monotonic: assert property (@(posedge r_clk) disable iff (!r_rst_n)
        1'b1 |=> (r_rep_cnt >= $past(r_rep_cnt)));
endmodule

bind tribuf_frame_sync tfs_checker #(.CNT_W(CNT_W)) i_chk (
    .w_clk(w_clk), .w_rst_n(w_rst_n), .w_start(w_start), .w_done(w_done),
    .w_size_bad(w_size_bad), .err_repeat_en(err_repeat_en),
    .r_clk(r_clk), .r_rst_n(r_rst_n), .r_start(r_start),
    .w_slot(w_slot), .r_slot(r_slot), .w_pub_g(w_pub_g),
    .w_rd_seen(w_rd_seen), .r_wr_seen(r_wr_seen), .w_act(w_act),
    .w_skip_cnt(w_skip_cnt), .r_rep_cnt(r_rep_cnt)
);

// File: tb/test_tribuf_frame_sync.sv
// Bench: both domains share one 50 MHz clock so the synchronizer delay is
// exact; a behavioural model is compared with every output each cycle.
module test_tribuf_frame_sync;
    localparam int CW  = 4;
    localparam int TOP = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic w_start = 0, w_done = 0, w_size_bad = 0, err_repeat_en = 1;
    logic r_start = 0, r_done = 0;
    logic [1:0] w_slot, r_slot;
    logic [CW-1:0] w_skip_cnt, w_rep_cnt, r_skip_cnt, r_rep_cnt;

    int n_tests = 0;
    int n_fail  = 0;
    bit cmp_on  = 0;

    always #10 clk = ~clk;

    tribuf_frame_sync #(.CNT_W(CW)) i_tribuf_frame_sync (
        .w_clk(clk), .w_rst_n(rst_n), .w_start(w_start), .w_done(w_done),
        .w_size_bad(w_size_bad), .err_repeat_en(err_repeat_en),
        .r_clk(clk), .r_rst_n(rst_n), .r_start(r_start), .r_done(r_done),
        .w_slot(w_slot), .r_slot(r_slot), .w_skip_cnt(w_skip_cnt),
        .w_rep_cnt(w_rep_cnt), .r_skip_cnt(r_skip_cnt), .r_rep_cnt(r_rep_cnt)
    );

    // Behavioural model state.
    int m_ws, m_rs, m_pub, m_wskip, m_wrep, m_rskip, m_rrep;
    bit m_wact, m_ract;
    int q_pub[$], q_ws[$], q_rs[$];

    function automatic int sat(int v);
        return (v > TOP) ? TOP : v;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ws = 0; m_rs = 0; m_pub = 0; m_wact = 0; m_ract = 0;
            m_wskip = 0; m_wrep = 0; m_rskip = 0; m_rrep = 0;
            q_pub = '{0, 0, 0}; q_ws = '{0, 0, 0}; q_rs = '{0, 0, 0};
        end else begin
            int pub_seen, ws_seen, rs_seen, n;
            pub_seen = q_pub[0]; ws_seen = q_ws[0]; rs_seen = q_rs[0];
            if (!m_wact) begin
                if (w_start) m_wact = 1;
            end else if (w_done) begin
                m_wact = 0;
                if (w_size_bad && err_repeat_en) m_wrep++;
                else begin
                    m_pub = m_ws;
                    n = (m_ws + 1) % 3;
                    if (n == rs_seen) begin n = (n + 1) % 3; m_wskip++; end
                    m_ws = n;
                end
            end
            if (!m_ract && r_start) begin
                m_ract = 1;
                if (pub_seen != m_rs && pub_seen != ws_seen) begin
                    if (pub_seen != (m_rs + 1) % 3) m_rskip++;
                    m_rs = pub_seen;
                end else m_rrep++;
            end else if (m_ract && r_done) m_ract = 0;
            q_pub.push_back(m_pub); void'(q_pub.pop_front());
            q_ws.push_back(m_ws);   void'(q_ws.pop_front());
            q_rs.push_back(m_rs);   void'(q_rs.pop_front());
        end
    end

    task automatic check(string req, string what, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Compare every output with the model away from the active edge.
    always @(negedge clk) begin
        if (cmp_on) begin
            check("R2", "w_slot", w_slot, m_ws);
            check("R5", "r_slot", r_slot, m_rs);
            check("R6", "w_skip_cnt", w_skip_cnt, sat(m_wskip));
            check("R3", "w_rep_cnt", w_rep_cnt, sat(m_wrep));
            check("R6", "r_skip_cnt", r_skip_cnt, sat(m_rskip));
            check("R5", "r_rep_cnt", r_rep_cnt, sat(m_rrep));
        end
    end

    // One cycle of strobes, set after a falling edge.
    task automatic drive(bit ws, bit wd, bit rs, bit rd);
        w_start = ws; w_done = wd; r_start = rs; r_done = rd;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cmp_on = 1;
        // R1: reset values
        check("R1", "w_slot reset", w_slot, 0);
        check("R1", "r_slot reset", r_slot, 0);
        check("R1", "w_skip reset", w_skip_cnt, 0);
        check("R1", "r_rep reset", r_rep_cnt, 0);
        // R4: done while idle is ignored on both sides
        drive(0, 1, 0, 1);
        drive(0, 0, 0, 0);
        check("R4", "w_slot after idle done", w_slot, 0);
        check("R4", "w_rep after idle done", w_rep_cnt, 0);
        // Two good write frames: slot 0 then slot 1 published
        drive(1, 0, 0, 0);
        drive(0, 1, 0, 0);
        check("R2", "w_slot after first frame", w_slot, 1);
        drive(1, 0, 0, 0);
        drive(0, 1, 0, 0);
        check("R2", "w_slot after second frame", w_slot, 2);
        // R7: reader start one edge later still sees the old published slot
        drive(0, 0, 1, 0);
        drive(0, 0, 0, 1);
        check("R7", "r_slot early start", r_slot, 0);
        check("R7", "r_rep early start", r_rep_cnt, 1);
        drive(0, 0, 0, 0);
        drive(0, 0, 1, 0);
        drive(0, 0, 0, 0);
        check("R7", "r_slot late start", r_slot, 1);
        check("R6", "r_skip sequential step", r_skip_cnt, 0);
        // R4: second start while reader active is ignored
        drive(0, 0, 1, 0);
        check("R4", "r_slot start while active", r_slot, 1);
        check("R4", "r_rep start while active", r_rep_cnt, 1);
        drive(0, 0, 0, 1);
        // R3: failed size check with error-repeat keeps the slot
        w_size_bad = 1;
        drive(1, 0, 0, 0);
        drive(0, 1, 0, 0);
        w_size_bad = 0;
        check("R3", "w_slot after bad frame", w_slot, 2);
        check("R3", "w_rep after bad frame", w_rep_cnt, 1);
        // Mixed traffic: writer fast, reader fast, then balanced
        for (int ph = 0; ph < 6; ph++) begin
            int wp, rp;
            wp = (ph % 3 == 0) ? 2 : ((ph % 3 == 1) ? 12 : 5);
            rp = (ph % 3 == 0) ? 12 : ((ph % 3 == 1) ? 2 : 6);
            err_repeat_en = ph[0];
            for (int c = 0; c < 1500; c++) begin
                w_size_bad = ($urandom % 5) == 0;
                drive(($urandom % wp) == 0, ($urandom % wp) == 0,
                      ($urandom % rp) == 0, ($urandom % rp) == 0);
            end
        end
        drive(0, 0, 0, 0);
        // R8: counters hold at all-ones once the model passes the limit
        if (m_wskip > TOP) check("R8", "w_skip saturated", w_skip_cnt, TOP);
        if (m_rrep > TOP)  check("R8", "r_rep saturated", r_rep_cnt, TOP);
        if (m_wrep > TOP)  check("R8", "w_rep saturated", w_rep_cnt, TOP);
        summary();
    end
endmodule